// File: doc/BRIEF.md
# Legacy Memory Window Address Router

This block sits on the CPU side of a system bridge. It looks at each memory request address and decides whether the request goes to main memory or to the I/O bus. It also says whether the access may be cached. Two legacy regions need special handling.

The first is the 512 KB to 1 MB shadow area. Boot code copies ROM images into this area. The area is split into 16 KB segments. Each segment has a read attribute and a write attribute, and the two are set separately. A typical setting lets reads hit memory with caching on, while writes pass through to the ROM on the I/O side.

The second is a software-defined hole inside the 1 MB to 16 MB range. Legacy devices with hardwired memory-mapped addresses live in this hole. Accesses that fall in the hole are sent to I/O.

Software sets up the segment attributes and the hole through a small write-only configuration port. Each request is marked with a valid strobe. The routing decision appears registered on the next clock.

Top module: `lmw_router`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` is 0. Reset clears every segment attribute to 0 and disables the hole, with base and limit both set to 0.
- R2: A request with `req_valid` = 1 at a clock edge gives `out_valid` = 1 for exactly the following cycle. With no request, `out_valid` is 0 in the following cycle.
- R3: Any address below 0x0008_0000 routes to memory (`out_route` = 0) with `out_cache` = 1, whatever the configuration.
- R4: Any address at or above 0x0100_0000 routes to memory with `out_cache` = 1, whatever the configuration.
- R5: When the hole is enabled, an address whose megabyte number (address bits 31:20) lies from 1 to 15 and from base to limit inclusive routes to I/O (`out_route` = 1) with `out_cache` = 0. Other addresses in 1 MB to 16 MB route to memory, cached.
- R6: When the hole is disabled, every address from 0x0010_0000 to 0x00FF_FFFF routes to memory, cached.
- R7: A read in the shadow area uses segment index (address − 0x0008_0000) >> 14. Its read attribute (bit 0) equal to 1 gives memory and cached. Equal to 0, it gives I/O and uncached.
- R8: A write in the shadow area uses that segment's write attribute (bit 1) in the same way, with no dependence on bit 0.
- R9: Configuration writes (`cfg_we` = 1) decode `cfg_addr` as follows. Values 0 to 31 set the attributes of that segment from `cfg_wdata[1:0]`. Value 32 sets the hole base, 33 sets the hole limit, each from `cfg_wdata[3:0]` in megabytes. Value 34 sets the enable from `cfg_wdata[0]`.
- R10: A request in the same cycle as a configuration write is routed with the old configuration. Requests from the next cycle on see the new value.
- R11: An enabled hole whose base is greater than its limit covers no address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration register select |
| cfg_wdata | input | 4 | Configuration write data |
| out_valid | output | 1 | Decision valid, one cycle after request |
| out_route | output | 1 | 0 = memory, 1 = I/O |
| out_cache | output | 1 | 1 = access may be cached |

## Verification
The bench builds the router with its default parameters: 32-bit addresses, thirty-two 16 KB segments, 1 MB hole granularity and a 16 MB legacy ceiling. This puts every segment edge within reach: 0x7FFFF, 0x80000, 0xFFFFF and 0x100000. It also exposes the last legal megabyte of the hole. Every segment gets its own attribute pattern, and each segment is probed with both a read and a write. The hole is tried disabled, enabled, and with base above limit. One configuration write is placed in the same cycle as a request to pin down the old-value ordering.

// File: rtl/lmw_pkg.sv
package lmw_pkg;
  typedef enum logic {
    ROUTE_MEM = 1'b0,
    ROUTE_IO  = 1'b1
  } route_t;
endpackage

// File: rtl/lmw_attr_file.sv
module lmw_attr_file #(
  parameter int SEG_COUNT = 32,
  parameter int CFG_AW    = 6,
  localparam int SEG_IW   = $clog2(SEG_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_sel,
  input  logic [1:0]        wr_attr,
  input  logic [SEG_IW-1:0] rd_idx,
  output logic [1:0]        rd_attr
);
  logic [1:0] attr_q [SEG_COUNT];
  logic       hit;

  assign hit = wr_en && (wr_sel < CFG_AW'(SEG_COUNT));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SEG_COUNT; i++) attr_q[i] <= 2'b00;
    end else if (hit) begin
      attr_q[wr_sel[SEG_IW-1:0]] <= wr_attr;
    end
  end

  assign rd_attr = attr_q[rd_idx];
endmodule

// File: rtl/lmw_hole_regs.sv
module lmw_hole_regs #(
  parameter int SEG_COUNT = 32,
  parameter int CFG_AW    = 6,
  parameter int MBW       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_sel,
  input  logic [MBW-1:0]    wr_data,
  output logic              hole_en,
  output logic [MBW-1:0]    hole_base,
  output logic [MBW-1:0]    hole_limit
);
  localparam logic [CFG_AW-1:0] SEL_BASE  = CFG_AW'(SEG_COUNT);
  localparam logic [CFG_AW-1:0] SEL_LIMIT = CFG_AW'(SEG_COUNT + 1);
  localparam logic [CFG_AW-1:0] SEL_EN    = CFG_AW'(SEG_COUNT + 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      hole_en    <= 1'b0;
      hole_base  <= '0;
      hole_limit <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_BASE)  hole_base  <= wr_data;
      if (wr_sel == SEL_LIMIT) hole_limit <= wr_data;
      if (wr_sel == SEL_EN)    hole_en    <= wr_data[0];
    end
  end
endmodule

// File: rtl/lmw_classify.sv
module lmw_classify
  import lmw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MB_SHIFT    = 20,
  parameter int HOLE_TOP_MB = 16,
  parameter int MBW         = 4,
  parameter logic [ADDR_W-1:0] SHADOW_LO = 32'h0008_0000,
  parameter logic [ADDR_W-1:0] SHADOW_HI = 32'h0010_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [1:0]        seg_attr,
  input  logic              hole_en,
  input  logic [MBW-1:0]    hole_base,
  input  logic [MBW-1:0]    hole_limit,
  output route_t            route,
  output logic              cache
);
  localparam int MBN = ADDR_W - MB_SHIFT;

  logic [MBN-1:0] mb;
  logic           in_shadow, in_legacy, in_hole, seg_bit;

  assign mb        = addr[ADDR_W-1:MB_SHIFT];
  assign in_shadow = (addr >= SHADOW_LO) && (addr < SHADOW_HI);
  assign in_legacy = (mb >= MBN'(1)) && (mb < MBN'(HOLE_TOP_MB));
  assign in_hole   = hole_en && in_legacy &&
                     (mb >= MBN'(hole_base)) && (mb <= MBN'(hole_limit));
  assign seg_bit   = we ? seg_attr[1] : seg_attr[0];

  always_comb begin
    route = ROUTE_MEM;
    cache = 1'b1;
    if (in_shadow) begin
      route = seg_bit ? ROUTE_MEM : ROUTE_IO;
      cache = seg_bit;
    end else if (in_hole) begin
      route = ROUTE_IO;
      cache = 1'b0;
    end
  end
endmodule

// File: rtl/lmw_router.sv
module lmw_router
  import lmw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SEG_COUNT   = 32,
  parameter int SEG_SHIFT   = 14,
  parameter int MB_SHIFT    = 20,
  parameter int HOLE_TOP_MB = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 req_valid,
  input  logic [ADDR_W-1:0]                    req_addr,
  input  logic                                 req_we,
  input  logic                                 cfg_we,
  input  logic [$clog2(SEG_COUNT+3)-1:0]       cfg_addr,
  input  logic [$clog2(HOLE_TOP_MB)-1:0]       cfg_wdata,
  output logic                                 out_valid,
  output logic                                 out_route,
  output logic                                 out_cache
);
  localparam int SEG_IW = $clog2(SEG_COUNT);
  localparam int CFG_AW = $clog2(SEG_COUNT + 3);
  localparam int MBW    = $clog2(HOLE_TOP_MB);
  localparam logic [ADDR_W-1:0] SHADOW_HI = ADDR_W'(1) << MB_SHIFT;
  localparam logic [ADDR_W-1:0] SHADOW_LO = SHADOW_HI - (ADDR_W'(SEG_COUNT) << SEG_SHIFT);
  localparam logic [ADDR_W-1:0] LEGACY_TOP = ADDR_W'(HOLE_TOP_MB) << MB_SHIFT;

  logic [SEG_IW-1:0] seg_idx;
  logic [1:0]        seg_attr;
  logic              hole_en;
  logic [MBW-1:0]    hole_base, hole_limit;
  route_t            route_d;
  logic              cache_d;

  assign seg_idx = req_addr[SEG_SHIFT +: SEG_IW];

  lmw_attr_file #(.SEG_COUNT(SEG_COUNT), .CFG_AW(CFG_AW)) attr_i (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_sel(cfg_addr),
    .wr_attr(cfg_wdata[1:0]), .rd_idx(seg_idx), .rd_attr(seg_attr)
  );

  lmw_hole_regs #(.SEG_COUNT(SEG_COUNT), .CFG_AW(CFG_AW), .MBW(MBW)) hole_i (
    .clk(clk), .rst(rst), .wr_en(cfg_we), .wr_sel(cfg_addr),
    .wr_data(cfg_wdata), .hole_en(hole_en), .hole_base(hole_base),
    .hole_limit(hole_limit)
  );

  lmw_classify #(
    .ADDR_W(ADDR_W), .MB_SHIFT(MB_SHIFT), .HOLE_TOP_MB(HOLE_TOP_MB),
    .MBW(MBW), .SHADOW_LO(SHADOW_LO), .SHADOW_HI(SHADOW_HI)
  ) cls_i (
    .addr(req_addr), .we(req_we), .seg_attr(seg_attr), .hole_en(hole_en),
    .hole_base(hole_base), .hole_limit(hole_limit),
    .route(route_d), .cache(cache_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_route <= 1'b0;
      out_cache <= 1'b0;
    end else begin
      out_valid <= req_valid;
      out_route <= req_valid ? (route_d == ROUTE_IO) : 1'b0;
      out_cache <= req_valid ? cache_d : 1'b0;
    end
  end

  // R2: one decision per strobe, none without
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);
  // R3: low area is always cached memory
  p_low_mem_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr < SHADOW_LO) |=> (out_valid && !out_route && out_cache));
  // R4: above the legacy ceiling is always cached memory
  p_high_mem_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr >= LEGACY_TOP) |=> (!out_route && out_cache));
  // R6: disabled hole never diverts the legacy range
  p_hole_off_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !hole_en && req_addr >= SHADOW_HI && req_addr < LEGACY_TOP)
    |=> (!out_route && out_cache));
endmodule

// File: tb/lmw_router_tb_top.sv
`timescale 1ns/1ps
module lmw_router_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_wdata = '0;
  logic        out_valid, out_route, out_cache;

  always #4 clk = ~clk;

  lmw_router dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_we(req_we), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_route(out_route),
    .out_cache(out_cache)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string note = "";

  // behavioural reference model
  int attr_m [32];
  int hen_m, hbase_m, hlim_m;
  int exp_v, exp_r, exp_c;
  string exp_tag;
  bit rst_d = 1;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) attr_m[i] = 0;
      hen_m = 0; hbase_m = 0; hlim_m = 0;
      exp_v = 0; exp_r = 0; exp_c = 0; exp_tag = "R1";
    end else begin
      exp_v = req_valid; exp_r = 0; exp_c = 0; exp_tag = "R2";
      if (req_valid) begin
        int unsigned a;
        a = req_addr;
        if (a < 32'h8_0000) begin
          exp_r = 0; exp_c = 1; exp_tag = "R3";
        end else if (a < 32'h10_0000) begin
          int seg, b;
          seg = (a - 32'h8_0000) >> 14;
          b = req_we ? ((attr_m[seg] >> 1) & 1) : (attr_m[seg] & 1);
          exp_r = b ? 0 : 1; exp_c = b;
          exp_tag = req_we ? "R8" : "R7";
        end else if (a >= 32'h100_0000) begin
          exp_r = 0; exp_c = 1; exp_tag = "R4";
        end else begin
          int mb;
          mb = a >> 20;
          if (!hen_m) exp_tag = "R6";
          else if (hbase_m > hlim_m) exp_tag = "R11";
          else exp_tag = "R5";
          if (hen_m && mb >= hbase_m && mb <= hlim_m) begin
            exp_r = 1; exp_c = 0;
          end else begin
            exp_r = 0; exp_c = 1;
          end
        end
      end
      // configuration takes effect after this edge's decision (R10, R9)
      if (cfg_we) begin
        if (cfg_addr < 32) attr_m[cfg_addr] = cfg_wdata & 3;
        else if (cfg_addr == 32) hbase_m = cfg_wdata;
        else if (cfg_addr == 33) hlim_m = cfg_wdata;
        else if (cfg_addr == 34) hen_m = cfg_wdata & 1;
      end
    end
  end

  always @(posedge clk) rst_d <= rst;

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (out_valid !== exp_v[0]) begin
        fails++;
        $display("FAIL %s %s valid: actual %b expected %0d", rst_d ? "R1" : "R2", note, out_valid, exp_v);
      end
      if (exp_v && !rst_d) begin
        checks++;
        if (out_route !== exp_r[0] || out_cache !== exp_c[0]) begin
          fails++;
          $display("FAIL %s %s route/cache: actual %b/%b expected %0d/%0d",
                   exp_tag, note, out_route, out_cache, exp_r, exp_c);
        end
      end
    end
  end

  task automatic cfg(input int a, input int d);
    @(negedge clk);
    req_valid = 0; cfg_we = 1; cfg_addr = 6'(a); cfg_wdata = 4'(d);
  endtask

  task automatic req(input logic [31:0] a, input logic w);
    @(negedge clk);
    cfg_we = 0; req_valid = 1; req_addr = a; req_we = w;
  endtask

  task automatic idle();
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle();
    // R1: default attributes route shadow reads and writes to I/O
    note = "R1";
    req(32'h0008_0000, 0); req(32'h000F_FFFF, 1);
    note = "";
    // R3 / R4 boundaries
    req(32'h0000_0000, 0); req(32'h0007_FFFF, 1);
    req(32'h0100_0000, 0); req(32'hFFFF_FFF0, 1);
    // R6: hole disabled
    req(32'h0010_0000, 0); req(32'h00FF_FFFF, 1);
    idle();
    // R9, R5: hole 3..5 MB
    note = "R9";
    cfg(32, 3); cfg(33, 5); cfg(34, 1);
    req(32'h002F_FFFF, 0); req(32'h0030_0000, 0); req(32'h0050_FFFF, 1);
    req(32'h0060_0000, 0); req(32'h0100_0000, 1);
    // hole reaching the last legal megabyte
    cfg(32, 15); cfg(33, 15);
    req(32'h00F0_0000, 0); req(32'h00FF_FFFF, 1); req(32'h0100_0000, 0);
    // R11: base above limit
    cfg(32, 7); cfg(33, 4);
    req(32'h0050_0000, 0); req(32'h0070_0000, 1);
    cfg(34, 0);
    req(32'h0040_0000, 0);
    // R7 / R8: every segment with its own pattern
    for (int s = 0; s < 32; s++) cfg(s, s % 4);
    for (int s = 0; s < 32; s++) begin
      req(32'h0008_0000 + (s << 14), 0);
      req(32'h0008_0000 + (s << 14) + 32'h3FFF, 1);
    end
    // R3 unaffected by shadow config
    req(32'h0007_FFFF, 0);
    // R10: config write and request in the same cycle
    note = "R10";
    cfg(2, 3);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 6'd2; cfg_wdata = 4'd0;
    req_valid = 1; req_addr = 32'h0008_8000; req_we = 0;
    req(32'h0008_8000, 0);
    idle(); idle();
    finish_run();
  end
endmodule